// File: doc/BRIEF.md
# Aperture Page-Table Address Translator

This block sits on the path between a 32-bit bus master and a 40-bit memory system. Bus addresses that land inside a programmable aperture window are remapped page by page, with 4 KiB pages, through a table of 32-bit entries held in an internal memory. Addresses outside the window pass through unchanged. Software programs the window and a flush word through a small register port, and loads table entries through a separate write port.

Each request is answered two cycles later, and a new request can be accepted every cycle. The most recently used entry is kept in a one-entry translation cache. Any table write, or a flush started through the flush word, empties that cache. A flush is reported as complete when the hardware clears the request bit.

Top module: `gart_xlate`

## Requirements
- R1: After reset every register reads as zero and the aperture is disabled, so a request at any address passes through with hit and miss both low.
- R2: Register select 0 is aperture control: bit 0 enables the window and bits 3:1 are an order n that sets the window size to 32 MiB << n. Register select 1 holds the window base in bits 14:0, in units of 32 MiB. The window covers base <= address < base + size.
- R3: A window whose end (base + size) reaches or passes 4 GiB is disabled, and all requests pass through untranslated.
- R4: The translated address is {entry[11:4], entry[31:12], bus[11:0]}, with hit high. Entry bit 0 is the valid flag. Entry bit 1 is the coherent attribute, which is output on rsp_coh with a hit and has no effect on the address. Entry bits 3:2 are reserved and must be zero for the entry to count as valid.
- R5: The table index is (bus address - window base) >> 12. Entries are loaded through the table port at index tbl_idx. An in-window index at or above TBL_DEPTH is a miss.
- R6: A request outside the window returns the bus address zero-extended to 40 bits, with hit and miss both low.
- R7: An in-window request whose entry is not valid returns address zero with miss high and hit low.
- R8: rsp_valid rises exactly two clock edges after the edge that accepts req_valid. Back-to-back requests give back-to-back responses, in order.
- R9: Writing register select 3 with bit 0 set starts a flush: bit 0 reads back as 1 for FLUSH_CYC cycles and then clears by itself, while bits 31:1 read back as written. A write with bit 0 clear starts no flush.
- R10: A table write invalidates the translation cache, so a later request to a page that was just rewritten returns the new entry.
- R11: Register selects 0, 1 and 2 (control, window base, table base) read back on reg_rdata exactly the word last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 control, 1 window base, 2 table base, 3 flush word) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | $clog2(TBL_DEPTH) | Table entry index |
| tbl_wdata | input | 32 | Table entry value |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Bus address to translate |
| rsp_valid | output | 1 | Response strobe, two cycles after the request |
| rsp_addr | output | 40 | Physical (or passed-through) address |
| rsp_hit | output | 1 | Address was translated through a valid entry |
| rsp_miss | output | 1 | In-window address with no valid entry |
| rsp_coh | output | 1 | Coherent attribute of the hitting entry |

## Verification
On every cycle, the assertions check the fixed two-cycle response timing, that hit and miss are never both high, that a miss returns zero, that a pass-through copies the bus address from two cycles earlier, that a hit keeps the page offset, and that a flush starts at once and ends within FLUSH_CYC cycles. Several behaviours can only be shown by the directed scenarios: the window arithmetic at its exact edges, the 4 GiB limit, the decoding of the entry fields into the 40-bit address, the reset state and register readback, and the stale-cache case where a page is rewritten between two requests.

// File: rtl/gart_pkg.sv
package gart_pkg;
    localparam int BUS_W  = 32;
    localparam int PHYS_W = 40;
    localparam int PG_SH  = 12;
    localparam int PG_W   = BUS_W - PG_SH;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_BASE  = 2'd1,
        SEL_TBASE = 2'd2,
        SEL_FLUSH = 2'd3
    } reg_sel_e;

    // An entry counts only with its valid bit set and the reserved field clear.
    function automatic logic ent_usable(input logic [31:0] e);
        return e[0] && (e[3:2] == 2'b00);
    endfunction

    // Page frame: high physical bits from entry[11:4], low from entry[31:12].
    function automatic logic [PHYS_W-PG_SH-1:0] ent_frame(input logic [31:0] e);
        return {e[11:4], e[31:12]};
    endfunction
endpackage

// File: rtl/gart_regs.sv
module gart_regs
    import gart_pkg::*;
#(
    parameter int FLUSH_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             win_on,
    output logic [PG_W-1:0]  win_lo_pg,
    output logic [PG_W-1:0]  win_hi_pg,
    output logic             flush_start,
    output logic             flush_busy
);
    localparam int CNT_W = (FLUSH_CYC > 1) ? $clog2(FLUSH_CYC) : 1;

    typedef struct packed {
        logic [31:0]      ctrl;
        logic [31:0]      base;
        logic [31:0]      tbase;
        logic [30:0]      fhi;
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } regs_t;

    regs_t q, d;

    logic [40:0] lo41, sz41, hi41;

    always_comb begin
        d           = q;
        flush_start = we && (reg_sel_e'(sel) == SEL_FLUSH) && wdata[0];

        if (q.busy) begin
            if (q.cnt == CNT_W'(FLUSH_CYC - 1)) begin
                d.busy = 1'b0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end

        if (we) begin
            unique case (reg_sel_e'(sel))
                SEL_CTRL:  d.ctrl  = wdata;
                SEL_BASE:  d.base  = wdata;
                SEL_TBASE: d.tbase = wdata;
                SEL_FLUSH: begin
                    d.fhi = wdata[31:1];
                    if (wdata[0]) begin
                        d.busy = 1'b1;
                        d.cnt  = '0;
                    end
                end
                default: ;
            endcase
        end

        // Window bounds in 41 bits so the 4 GiB limit is visible.
        lo41      = {1'b0, q.base[14:0], 25'd0};
        sz41      = 41'h0_0200_0000 << q.ctrl[3:1];
        hi41      = lo41 + sz41;
        win_on    = q.ctrl[0] && (hi41 < 41'h1_0000_0000);
        win_lo_pg = lo41[31:12];
        win_hi_pg = hi41[31:12];

        unique case (reg_sel_e'(sel))
            SEL_CTRL:  rdata = q.ctrl;
            SEL_BASE:  rdata = q.base;
            SEL_TBASE: rdata = q.tbase;
            default:   rdata = {q.fhi, q.busy};
        endcase
    end

    assign flush_busy = q.busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/gart_table.sv
module gart_table #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    logic [31:0] mem_q [DEPTH];
    logic [31:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we && (32'(widx) < DEPTH)) begin
            mem_d[widx] = wdata;
        end
    end

    assign rdata = (32'(ridx) < DEPTH) ? mem_q[ridx] : 32'd0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end
endmodule

// File: rtl/gart_pipe.sv
module gart_pipe
    import gart_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [BUS_W-1:0]  req_addr,
    input  logic              win_on,
    input  logic [PG_W-1:0]   win_lo_pg,
    input  logic [PG_W-1:0]   win_hi_pg,
    input  logic              inval,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [31:0]       rd_ent,
    output logic              rsp_valid,
    output logic [PHYS_W-1:0] rsp_addr,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_coh
);
    typedef struct packed {
        logic              s1_v;
        logic              s1_in;
        logic              s1_rng;
        logic [IDX_W-1:0]  s1_idx;
        logic [BUS_W-1:0]  s1_addr;
        logic              c_v;
        logic [IDX_W-1:0]  c_tag;
        logic [31:0]       c_ent;
        logic              r_v;
        logic [PHYS_W-1:0] r_addr;
        logic              r_hit;
        logic              r_miss;
        logic              r_coh;
    } pipe_t;

    pipe_t q, d;

    logic [PG_W-1:0] pg_in, pg_rel;
    logic            in_win, use_c;
    logic [31:0]     ent;

    always_comb begin
        d = q;

        // Stage 1: window decode and index.
        pg_in    = req_addr[BUS_W-1:PG_SH];
        pg_rel   = pg_in - win_lo_pg;
        in_win   = win_on && (pg_in >= win_lo_pg) && (pg_in < win_hi_pg);
        d.s1_v   = req_valid;
        d.s1_in  = in_win;
        d.s1_rng = ((pg_rel >> IDX_W) == '0);
        d.s1_idx = pg_rel[IDX_W-1:0];
        d.s1_addr = req_addr;

        // Stage 2: entry lookup through the one-entry cache.
        use_c = q.c_v && (q.c_tag == q.s1_idx);
        ent   = use_c ? q.c_ent : rd_ent;

        if (q.s1_v && q.s1_in && q.s1_rng && !use_c) begin
            d.c_v   = 1'b1;
            d.c_tag = q.s1_idx;
            d.c_ent = rd_ent;
        end
        if (inval) begin
            d.c_v = 1'b0;
        end

        d.r_v    = q.s1_v;
        d.r_addr = '0;
        d.r_hit  = 1'b0;
        d.r_miss = 1'b0;
        d.r_coh  = 1'b0;
        if (q.s1_v) begin
            if (!q.s1_in) begin
                d.r_addr = {{(PHYS_W-BUS_W){1'b0}}, q.s1_addr};
            end else if (q.s1_rng && ent_usable(ent)) begin
                d.r_addr = {ent_frame(ent), q.s1_addr[PG_SH-1:0]};
                d.r_hit  = 1'b1;
                d.r_coh  = ent[1];
            end else begin
                d.r_miss = 1'b1;
            end
        end
    end

    assign rd_idx    = q.s1_idx;
    assign rsp_valid = q.r_v;
    assign rsp_addr  = q.r_addr;
    assign rsp_hit   = q.r_hit;
    assign rsp_miss  = q.r_miss;
    assign rsp_coh   = q.r_coh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/gart_xlate.sv
module gart_xlate
    import gart_pkg::*;
#(
    parameter int TBL_DEPTH = 64,
    parameter int FLUSH_CYC = 4,
    localparam int IDX_W    = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [31:0]       tbl_wdata,
    input  logic              req_valid,
    input  logic [BUS_W-1:0]  req_addr,
    output logic              rsp_valid,
    output logic [PHYS_W-1:0] rsp_addr,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_coh
);
    logic            win_on;
    logic [PG_W-1:0] win_lo_pg, win_hi_pg;
    logic            flush_start, flush_busy;
    logic [IDX_W-1:0] rd_idx;
    logic [31:0]     rd_ent;
    logic            inval;

    assign inval = tbl_we || flush_start;

    gart_regs #(.FLUSH_CYC(FLUSH_CYC)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .rdata(reg_rdata), .win_on(win_on), .win_lo_pg(win_lo_pg),
        .win_hi_pg(win_hi_pg), .flush_start(flush_start), .flush_busy(flush_busy)
    );

    gart_table #(.DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .wdata(tbl_wdata),
        .ridx(rd_idx), .rdata(rd_ent)
    );

    gart_pipe #(.IDX_W(IDX_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .win_on(win_on), .win_lo_pg(win_lo_pg), .win_hi_pg(win_hi_pg),
        .inval(inval), .rd_idx(rd_idx), .rd_ent(rd_ent),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit),
        .rsp_miss(rsp_miss), .rsp_coh(rsp_coh)
    );
endmodule

// File: rtl/gart_xlate_chk.sv
module gart_xlate_chk #(
    parameter int FLUSH_CYC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [1:0]  reg_sel,
    input logic [31:0] reg_wdata,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        rsp_valid,
    input logic [39:0] rsp_addr,
    input logic        rsp_hit,
    input logic        rsp_miss,
    input logic        flush_busy
);
    logic        wr_flush;
    logic [31:0] busy_run;

    assign wr_flush = reg_we && (reg_sel == 2'd3) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (wr_flush) begin
            busy_run <= 32'd1;
        end else if (flush_busy) begin
            busy_run <= busy_run + 32'd1;
        end else begin
            busy_run <= '0;
        end
    end

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ##1 rsp_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ##1 !rsp_valid);

    a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_addr == 40'd0) && !rsp_hit);

    a_r6_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !rsp_miss) |-> (rsp_addr == {8'd0, $past(req_addr, 2)}));

    a_r4_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_addr[11:0] == $past(req_addr[11:0], 2)));

    a_r9_flush_start: assert property (@(posedge clk) disable iff (!rst_n)
        wr_flush |=> flush_busy);

    a_r9_flush_bound: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> (busy_run <= 32'(FLUSH_CYC)));
endmodule

bind gart_xlate gart_xlate_chk #(.FLUSH_CYC(FLUSH_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .flush_busy(flush_busy)
);

// File: tb/tb_gart_xlate.sv
module tb_gart_xlate;
    localparam int DEPTH = 64;
    localparam int FCYC  = 4;
    localparam int IW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic [31:0] tbl_wdata = 32'd0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = 32'd0;
    logic        rsp_valid;
    logic [39:0] rsp_addr;
    logic        rsp_hit, rsp_miss, rsp_coh;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] sh_ctrl = 32'd0;
    logic [31:0] sh_base = 32'd0;
    logic [31:0] sh_tbl [DEPTH];

    always #10 clk = ~clk;

    gart_xlate #(.TBL_DEPTH(DEPTH), .FLUSH_CYC(FCYC)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_coh(rsp_coh)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: {valid, hit, miss, coh, addr}
    function automatic logic [43:0] model(input logic [31:0] a);
        logic [40:0] lo, hi;
        logic [31:0] e;
        logic [19:0] pg;
        logic        on, inw;
        lo  = {1'b0, sh_base[14:0], 25'd0};
        hi  = lo + (41'h200_0000 << sh_ctrl[3:1]);
        on  = sh_ctrl[0] && (hi < 41'h1_0000_0000);
        inw = on && ({9'd0, a} >= lo) && ({9'd0, a} < hi);
        if (!inw) return {4'b1000, 8'd0, a};
        pg = a[31:12] - lo[31:12];
        if (pg >= 20'(DEPTH)) return {4'b1010, 40'd0};
        e = sh_tbl[pg[IW-1:0]];
        if (!(e[0] && e[3:2] == 2'b00)) return {4'b1010, 40'd0};
        return {3'b110, e[1], e[11:4], e[31:12], a[11:0]};
    endfunction

    function automatic logic [43:0] got();
        return {rsp_valid, rsp_hit, rsp_miss, rsp_coh, rsp_addr};
    endfunction

    task automatic wr_reg(input logic [1:0] s, input logic [31:0] v);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        if (s == 2'd0) sh_ctrl = v;
        if (s == 2'd1) sh_base = v;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic wr_ent(input int i, input logic [31:0] v);
        tbl_we = 1'b1; tbl_idx = IW'(i); tbl_wdata = v;
        @(negedge clk);
        tbl_we = 1'b0;
        sh_tbl[i] = v;
    endtask

    task automatic xlate(input string req, input logic [31:0] a);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(req, 64'(got()), 64'(model(a)));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            check("R1 reg zero", 64'(v), 64'd0);
        end
        xlate("R1 disabled passthru", 32'h0200_0000);
        check("R1 no hit", 64'(rsp_hit), 64'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr_reg(2'd2, 32'h0123_4567);
        rd_reg(2'd2, v);
        check("R11 table base", 64'(v), 64'h0123_4567);
        wr_reg(2'd1, 32'hA5A5_0001);
        rd_reg(2'd1, v);
        check("R11 base", 64'(v), 64'hA5A5_0001);
        wr_reg(2'd0, 32'hF000_0001);
        rd_reg(2'd0, v);
        check("R11 ctrl", 64'(v), 64'hF000_0001);
    endtask

    task automatic t_basic();
        wr_reg(2'd1, 32'd1);
        wr_reg(2'd0, 32'd1);
        wr_ent(0, 32'hABCDE_5A3);
        wr_ent(63, 32'h12345_FF1);
        wr_ent(5, 32'h77777_010);
        wr_ent(6, 32'h66666_00D);
        xlate("R4 hit idx0", 32'h0200_0123);
        check("R4 phys addr", 64'(rsp_addr), 64'h5A_ABCD_E123);
        xlate("R4 hit idx63 coh clear", 32'h0203_FFFF);
        check("R4 coh flag", 64'(rsp_coh), 64'd0);
        xlate("R7 invalid entry", 32'h0200_5004);
        xlate("R4 reserved bits miss", 32'h0200_6000);
        xlate("R5 index beyond depth", 32'h0204_0000);
        xlate("R5 last in-window page", 32'h03FF_FFFF);
    endtask

    task automatic t_outside();
        xlate("R6 below window", 32'h01FF_FFFF);
        xlate("R6 at window end", 32'h0400_0000);
        xlate("R6 high address", 32'hFFFF_F123);
    endtask

    task automatic t_order();
        wr_reg(2'd1, 32'd2);
        wr_reg(2'd0, 32'h5);
        wr_ent(3, 32'h00FED_013);
        xlate("R2 order2 idx3", 32'h0400_3ABC);
        check("R2 order2 hit", 64'(rsp_hit), 64'd1);
        xlate("R2 order2 inside far", 32'h0BFF_F000);
        check("R2 order2 miss", 64'(rsp_miss), 64'd1);
        xlate("R2 order2 end", 32'h0C00_0000);
        wr_reg(2'd0, 32'h4);
        xlate("R2 enable clear", 32'h0400_3ABC);
    endtask

    task automatic t_limit();
        wr_reg(2'd1, 32'h7E);
        wr_reg(2'd0, 32'h1);
        xlate("R3 just below 4G", 32'hFC00_0123);
        check("R3 below limit hit", 64'(rsp_hit), 64'd1);
        wr_reg(2'd1, 32'h7F);
        xlate("R3 reaching 4G", 32'hFE00_0123);
        check("R3 reach no hit", 64'(rsp_hit), 64'd0);
        wr_reg(2'd1, 32'h0);
        wr_reg(2'd0, 32'hF);
        xlate("R3 order7 disabled", 32'h0000_0123);
    endtask

    task automatic t_pipe();
        logic [31:0] a [3];
        a[0] = 32'h0200_0010; a[1] = 32'h0100_0020; a[2] = 32'h0203_F030;
        wr_reg(2'd1, 32'd1);
        wr_reg(2'd0, 32'd1);
        req_valid = 1'b1; req_addr = a[0];
        @(negedge clk);
        check("R8 not yet valid", 64'(rsp_valid), 64'd0);
        req_addr = a[1];
        @(negedge clk);
        check("R8 pipe 0", 64'(got()), 64'(model(a[0])));
        req_addr = a[2];
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 pipe 1", 64'(got()), 64'(model(a[1])));
        @(negedge clk);
        check("R8 pipe 2", 64'(got()), 64'(model(a[2])));
        @(negedge clk);
        check("R8 drained", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_cache();
        wr_ent(9, 32'h11111_0A1);
        xlate("R10 first fill", 32'h0200_9444);
        wr_ent(9, 32'h22222_0B3);
        xlate("R10 after rewrite", 32'h0200_9444);
        check("R10 new frame", 64'(rsp_addr), 64'h0B_2222_2444);
        wr_ent(9, 32'h22222_0B0);
        xlate("R10 invalidated entry", 32'h0200_9444);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        wr_reg(2'd3, 32'hDEAD_BEE0);
        rd_reg(2'd3, v);
        check("R9 no start", 64'(v), 64'hDEAD_BEE0);
        wr_reg(2'd3, 32'h1234_5671);
        for (int k = 0; k < FCYC; k++) begin
            rd_reg(2'd3, v);
            check("R9 busy", 64'(v), 64'h1234_5671);
            @(negedge clk);
        end
        rd_reg(2'd3, v);
        check("R9 done", 64'(v), 64'h1234_5670);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) sh_tbl[i] = 32'd0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_regs();
                t_basic();
                t_outside();
                t_order();
                t_limit();
                t_pipe();
                t_cache();
                t_flush();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule